// File: doc/BRIEF.md
# Byte Block Copy and Search Sequencer

This block carries out the byte-block instructions of an 8-bit CPU core. It handles a single copy, a repeating copy, a single compare and a repeating compare. Each of them can step upward or downward through memory. The core supplies a start pulse, a 3-bit operation code and the current A, F, BC, DE, HL, PC and MEMPTR values. The block then reads one byte through a synchronous memory port. For a copy it writes that byte back out at DE. After that it returns the updated pointers, counter, flags, PC, MEMPTR and a T-state count, together with a one-cycle done pulse.

A repeating instruction runs exactly one iteration for each start. When another iteration is needed, the block lowers PC by two, so the core fetches the same instruction again. All pointer and counter arithmetic is 16-bit and wraps.

Top module: `blkmove_seq`

## Requirements
- R1: While reset is held and after it is released, done, mem_rd and mem_wr are 0, and f_out, bc_out, de_out, hl_out, pc_out, mptr_out and tstates are all 0.
- R2: The operation code is decoded as follows. Bit 0 set means compare, and clear means copy. Bit 1 set means decrement, and clear means increment. Bit 2 set means repeating. A copy reads the byte at HL and writes it to address DE. HL and DE then both step by +1 (increment) or −1 (decrement), modulo 65536.
- R3: After a copy, F bits 7, 6 and 0 are unchanged and bits 4 and 1 are 0. Take s = (byte + A) mod 256. Then F bit 3 = s bit 3 and F bit 5 = s bit 1.
- R4: A compare computes r = (A − byte) mod 256. It steps HL, leaves DE unchanged and performs no memory write. F bit 7 = r bit 7, F bit 6 = (r == 0), and F bit 1 = 1. F bit 4 is set when A[3:0] < byte[3:0], and F bit 0 is unchanged.
- R5: After a compare, take n = (r − F bit 4) mod 256. Then F bit 3 = n bit 3 and F bit 5 = n bit 1.
- R6: Every operation returns BC − 1 modulo 65536, and F bit 2 is set exactly when that value is nonzero. A starting BC of 0 yields 0xFFFF.
- R7: A repeating copy continues when the new BC is nonzero. A repeating compare continues when the new BC is nonzero and F bit 6 is clear. On a continuing iteration, tstates = 21, pc_out = PC − 2 and mptr_out = PC − 1.
- R8: A non-repeating operation, or a repeating one that stops, returns tstates = 16 and pc_out = PC. In that case a copy leaves MEMPTR unchanged.
- R9: When a compare does not continue, MEMPTR is set as follows:
  - single increment: PC − 1
  - single decrement: MEMPTR − 1
  - repeating increment that stops: PC
  - repeating decrement that stops: PC − 2
- R10: Timing from the clock edge that samples start:
  - mem_rd with address HL is asserted for the next cycle.
  - For a copy, mem_wr with address DE is asserted in the cycle after that.
  - done is high for exactly one cycle, the fourth after the sampling edge, and the outputs hold until the next start.
  - A start that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one operation (sampled when idle) |
| op | input | 3 | {repeat, decrement, compare} |
| a_in | input | 8 | Accumulator |
| f_in | input | 8 | Flags before the operation |
| bc_in | input | 16 | Byte counter |
| de_in | input | 16 | Destination pointer |
| hl_in | input | 16 | Source pointer |
| pc_in | input | 16 | PC after the instruction fetch |
| mptr_in | input | 16 | Hidden address register before the operation |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_rd |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| f_out | output | 8 | New flags |
| bc_out | output | 16 | New counter |
| de_out | output | 16 | New destination pointer |
| hl_out | output | 16 | New source pointer |
| pc_out | output | 16 | New PC |
| mptr_out | output | 16 | New hidden address register |
| tstates | output | 5 | T-state count of this iteration |
| done | output | 1 | One-cycle completion pulse |

## Verification
Three situations are the hardest to reach from the ports.

- **Repeating compare stopped by a match while BC is still nonzero.** The bench reaches this by placing a byte equal to A at HL on purpose, with BC set above 1.
- **The counter wrapping from BC = 0.** The bench starts a repeating copy with BC = 0.
- **HL at 0xFFFF stepping up.** The bench sets HL to 0xFFFF before a copy-increment.

A second start is pulsed in the middle of an operation, carrying different register values, to show that it has no effect. Directed and random vectors are each compared cycle by cycle against a behavioural model that works in integer arithmetic.

// File: rtl/blkmove_seq.sv
module blkmove_seq #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int T_FINAL = 16,
  parameter int T_LOOP = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] f_in,
  input  logic [AW-1:0] bc_in,
  input  logic [AW-1:0] de_in,
  input  logic [AW-1:0] hl_in,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] mptr_in,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] f_out,
  output logic [AW-1:0] bc_out,
  output logic [AW-1:0] de_out,
  output logic [AW-1:0] hl_out,
  output logic [AW-1:0] pc_out,
  output logic [AW-1:0] mptr_out,
  output logic [4:0]    tstates,
  output logic          done
);
  typedef enum logic [2:0] {S_IDLE, S_READ, S_XFER, S_UPD, S_DONE} st_t;
  st_t st;

  logic [2:0]    op_l;
  logic [DW-1:0] a_l, f_l, dat;
  logic [AW-1:0] bc_l, de_l, hl_l, pc_l, mp_l;

  wire cmp = op_l[0];
  wire dn  = op_l[1];
  wire rpt = op_l[2];

  wire [AW-1:0] bc_nx = bc_l - 1'b1;
  wire          bcnz  = |bc_nx;
  wire [AW-1:0] hl_nx = dn ? hl_l - 1'b1 : hl_l + 1'b1;
  wire [AW-1:0] de_nx = cmp ? de_l : (dn ? de_l - 1'b1 : de_l + 1'b1);

  wire [DW-1:0] sum = dat + a_l;
  wire [DW-1:0] dif = a_l - dat;
  wire          hc  = a_l[3:0] < dat[3:0];
  wire          zr  = (dif == '0);
  wire [DW-1:0] nn  = dif - {{(DW-1){1'b0}}, hc};

  wire [DW-1:0] xy_cpy = (sum & 8'h08) | ((sum & 8'h02) << 4);
  wire [DW-1:0] xy_cmp = (nn & 8'h08) | ((nn & 8'h02) << 4);
  wire [DW-1:0] f_cpy  = (f_l & 8'hC1) | xy_cpy | {5'b0, bcnz, 2'b0};
  wire [DW-1:0] f_cmp  = (f_l & 8'h01) | xy_cmp |
                         {dif[7], zr, 1'b0, hc, 1'b0, bcnz, 1'b1, 1'b0};

  wire again = rpt & bcnz & ~(cmp & zr);

  logic [AW-1:0] mp_nx;
  always_comb begin
    if (again)     mp_nx = pc_l - 1'b1;
    else if (!cmp) mp_nx = mp_l;
    else if (!dn)  mp_nx = rpt ? pc_l : pc_l - 1'b1;
    else           mp_nx = rpt ? pc_l - 2'd2 : mp_l - 1'b1;
  end

  assign mem_rd    = (st == S_READ);
  assign mem_wr    = (st == S_XFER) & ~cmp;
  assign mem_addr  = (st == S_XFER) ? de_l : hl_l;
  assign mem_wdata = mem_rdata;
  assign done      = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op_l <= '0; a_l <= '0; f_l <= '0; dat <= '0;
      bc_l <= '0; de_l <= '0; hl_l <= '0; pc_l <= '0; mp_l <= '0;
      f_out <= '0; bc_out <= '0; de_out <= '0; hl_out <= '0;
      pc_out <= '0; mptr_out <= '0; tstates <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_l <= op; a_l <= a_in; f_l <= f_in;
          bc_l <= bc_in; de_l <= de_in; hl_l <= hl_in;
          pc_l <= pc_in; mp_l <= mptr_in;
          st <= S_READ;
        end
        S_READ: st <= S_XFER;
        S_XFER: begin
          dat <= mem_rdata;
          st <= S_UPD;
        end
        S_UPD: begin
          f_out    <= cmp ? f_cmp : f_cpy;
          bc_out   <= bc_nx;
          de_out   <= de_nx;
          hl_out   <= hl_nx;
          pc_out   <= again ? pc_l - 2'd2 : pc_l;
          mptr_out <= mp_nx;
          tstates  <= again ? 5'(T_LOOP) : 5'(T_FINAL);
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blkmove_seq_chk.sv
module blkmove_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [4:0]  tstates,
  input logic [15:0] pc_out,
  input logic [15:0] pc_l,
  input logic [7:0]  f_out,
  input logic [2:0]  op_l
);
  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_wr_follows_rd: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd));
  a_r10_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  a_r7_tstate_values: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tstates == 5'd16 || tstates == 5'd21));
  a_r7_loop_rewinds_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (done && tstates == 5'd21) |-> pc_out == pc_l - 16'd2);
  a_r8_final_keeps_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (done && tstates == 5'd16) |-> pc_out == pc_l);
  a_r3_copy_clears_hn: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !op_l[0]) |-> (!f_out[4] && !f_out[1]));
  a_r4_compare_sets_n: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_l[0]) |-> f_out[1]);
endmodule

bind blkmove_seq blkmove_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .tstates(tstates), .pc_out(pc_out), .pc_l(pc_l), .f_out(f_out), .op_l(op_l)
);

// File: tb/blkmove_seq_test.sv
module blkmove_seq_test;
  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] op = 0;
  logic [7:0] a_in = 0, f_in = 0, mem_rdata = 0;
  logic [15:0] bc_in = 0, de_in = 0, hl_in = 0, pc_in = 0, mptr_in = 0;
  logic [15:0] mem_addr, bc_out, de_out, hl_out, pc_out, mptr_out;
  logic mem_rd, mem_wr, done;
  logic [7:0] mem_wdata, f_out;
  logic [4:0] tstates;

  always #2 clk = ~clk;

  blkmove_seq uut (.*);

  logic [7:0] mem [256];
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
  end

  int vectors = 0, errs = 0;
  bit finished = 0;

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(int o, int a, int f, int bc, int de, int hl, int pc, int mp,
                     bit poke);
    int d, dpre, cmp, dn, rpt, bcn, r, h, n, s, ef, again, emp, z;
    d = mem[hl % 256]; dpre = mem[de % 256];
    cmp = o % 2; dn = (o / 2) % 2; rpt = o / 4;
    bcn = (bc + 65535) % 65536;
    if (cmp != 0) begin
      r = (a - d + 256) % 256;
      h = ((a % 16) < (d % 16)) ? 1 : 0;
      n = (r - h + 256) % 256;
      z = (r == 0) ? 1 : 0;
      ef = (r / 128) * 128 + z * 64 + ((n / 2) % 2) * 32 + h * 16 + ((n / 8) % 2) * 8
           + (bcn != 0 ? 4 : 0) + 2 + f % 2;
    end else begin
      s = (a + d) % 256; z = 0;
      ef = (f / 128) * 128 + ((f / 64) % 2) * 64 + ((s / 2) % 2) * 32 + ((s / 8) % 2) * 8
           + (bcn != 0 ? 4 : 0) + f % 2;
    end
    again = (rpt != 0 && bcn != 0 && !(cmp != 0 && z != 0)) ? 1 : 0;
    if (again != 0) emp = (pc + 65535) % 65536;
    else if (cmp == 0) emp = mp;
    else if (dn == 0) emp = (rpt != 0) ? pc : (pc + 65535) % 65536;
    else emp = (rpt != 0) ? (pc + 65534) % 65536 : (mp + 65535) % 65536;

    @(negedge clk);
    op = 3'(o); a_in = 8'(a); f_in = 8'(f); bc_in = 16'(bc); de_in = 16'(de);
    hl_in = 16'(hl); pc_in = 16'(pc); mptr_in = 16'(mp); start = 1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      start = 0;
      if (poke && k == 2) begin
        start = 1; op = ~op; hl_in = ~hl_in; bc_in = 16'h0001; pc_in = 16'h1234;
      end
      chk("R10 done timing", int'(done), (k == 4) ? 1 : 0);
      if (k == 1) begin
        chk("R10 read strobe", int'(mem_rd), 1);
        chk("R2 read addr HL", int'(mem_addr), hl);
      end
      if (k == 2) begin
        chk("R10 write strobe", int'(mem_wr), (cmp == 0) ? 1 : 0);
        if (cmp == 0) chk("R2 write addr DE", int'(mem_addr), de);
      end
    end
    start = 0;
    chk(cmp != 0 ? "R4/R5 flags" : "R3 flags", int'(f_out), ef);
    chk("R6 bc", int'(bc_out), bcn);
    chk("R2 hl step", int'(hl_out), dn != 0 ? (hl + 65535) % 65536 : (hl + 1) % 65536);
    if (cmp != 0) chk("R4 de kept", int'(de_out), de);
    else chk("R2 de step", int'(de_out), dn != 0 ? (de + 65535) % 65536 : (de + 1) % 65536);
    chk("R7/R8 pc", int'(pc_out), again != 0 ? (pc + 65534) % 65536 : pc);
    chk("R7/R8/R9 memptr", int'(mptr_out), emp);
    chk("R7/R8 tstates", int'(tstates), again != 0 ? 21 : 16);
    chk("R2/R4 memory at DE", int'(mem[de % 256]),
        (cmp == 0) ? d : ((de % 256 == hl % 256) ? d : dpre));
    @(negedge clk);
    chk("R10 done single", int'(done), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) % 256);
    repeat (3) @(negedge clk);
    chk("R1 done", int'(done), 0);
    chk("R1 rd", int'(mem_rd), 0);
    chk("R1 wr", int'(mem_wr), 0);
    chk("R1 regs", int'(f_out) + int'(bc_out) + int'(pc_out) + int'(tstates) + int'(mptr_out), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", int'(done) + int'(mem_rd) + int'(mem_wr), 0);
    mem[8'h10] = 8'h2A;
    run(0, 8'h10, 8'hFF, 5, 16'h2020, 16'h4010, 16'h8002, 16'h0777, 0); // R2 R3
    run(2, 8'h00, 8'h00, 1, 16'h2040, 16'h4010, 16'h8002, 16'h0777, 0); // R3 dec, BC->0
    mem[8'h30] = 8'h55;
    run(5, 8'h55, 8'h01, 9, 16'h0000, 16'h0030, 16'h9000, 16'h1111, 0); // R7 stop on match
    run(5, 8'h54, 8'h00, 9, 16'h0000, 16'h0030, 16'h9000, 16'h1111, 0); // R7 continue
    run(7, 8'h01, 8'h00, 1, 16'h0000, 16'h0031, 16'h9000, 16'h1111, 0); // R9 stop dec
    run(3, 8'h01, 8'h00, 4, 16'h0000, 16'h0031, 16'h9000, 16'h1111, 0); // R9 single dec
    run(1, 8'h01, 8'h01, 4, 16'h0000, 16'h0031, 16'h0000, 16'h1111, 0); // R9 single inc, PC wrap
    run(4, 8'h33, 8'h40, 0, 16'h1050, 16'hFFFF, 16'h0100, 16'h2222, 0); // R6 BC wrap, R2 HL wrap
    run(6, 8'h33, 8'h80, 1, 16'h1050, 16'h0060, 16'h0100, 16'h2222, 0); // R8 final copy
    run(0, 8'h77, 8'h00, 3, 16'h2088, 16'h4044, 16'h0300, 16'h3333, 1); // R10 start ignored
    for (int t = 0; t < 40; t++)
      run(int'($urandom % 8), int'($urandom % 256), int'($urandom % 256),
          int'($urandom % 4), int'($urandom % 65536), int'($urandom % 65536),
          int'($urandom % 65536), int'($urandom % 65536), (t % 5) == 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule